// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This controller turns single-cycle processor requests into the two-phase strobe sequence that an asynchronous DRAM array with a shared row/column address bus expects. A request carries the full flat address, a write flag and the write data. The controller splits the address into its row and column parts. It places the row on the memory address pins and raises the row strobe. After the row-to-column delay it places the column and raises the column strobe. At the end of the column pulse it completes the access with a one-cycle done pulse, and for a read it also returns the captured data.

Once a row is open, the controller keeps the row strobe high. A later request to the same row is then served by a column pulse alone, which removes the activation and precharge time from each access in the burst. The row closes in three cases: a request targets another row, a refresh falls due, or no request arrives for a set number of cycles. An internal interval timer requests a refresh of one row at a time. Each refresh is a row-only activation, and a counter selects the row and steps through every row in turn. A due refresh always wins over new processor work, but it only starts at a boundary between accesses.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset both strobes, the write enable and the done pulse are low, and the request-ready output is high.
- R2: The row is the upper ROW_W address bits and the column is the lower COL_W bits. The row appears on the address pins in the cycle the row strobe rises. The column, zero-extended, appears there in the cycle the column strobe rises.
- R3: The column strobe is high only while the row strobe is high, and it rises no earlier than T_RCD cycles after the row strobe rose.
- R4: Every column pulse lasts exactly T_CAS cycles. Write enable is high only during a pulse for a write, and the write enable, write data and address pins stay unchanged for the whole pulse.
- R5: The done output is a single-cycle pulse. It is raised in the cycle the column strobe falls. For a read, the data-out port shows the value the memory drove at the end of the pulse.
- R6: A request accepted while a row is open and addressed to that row causes no new row activation. Only a column pulse is issued.
- R7: A request to a row other than the open one first drops the row strobe, and then activates the new row.
- R8: A refresh is requested every REF_PERIOD cycles. It is a row-strobe-only activation lasting T_RAS_REF cycles with no column pulse. The refreshed row starts at 0, rises by one per refresh and wraps after 2^ROW_W rows.
- R9: While a refresh is due the controller accepts no request, and any open row is closed before the refresh runs. As a result, consecutive refreshes stay within a bounded distance of the timer period even when requests arrive back to back.
- R10: With a row open and no request presented, the row strobe drops IDLE_CLOSE cycles after the done pulse.
- R11: The row strobe stays low for at least T_RP cycles before every rise.
- R12: Data written to any address is returned by a later read of that address, whatever the order of the accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ROW_W+COL_W | Flat word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | The presented request is accepted this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with the done pulse of a read |
| mem_ras | output | 1 | Row strobe, active high |
| mem_cas | output | 1 | Column strobe, active high |
| mem_we | output | 1 | Memory write enable, active high |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| mem_dout | output | DATA_W | Data driven to the memory |
| mem_din | input | DATA_W | Data returned by the memory |

## Verification
The bench builds the controller with ROW_W=4, COL_W=3, T_RAS_REF=3, REF_PERIOD=50 and IDLE_CLOSE=6. That gives a 128-word array, which is small enough to write and read every address in row-major, column-major and strided orders. Those orders produce long runs of page hits as well as a page miss on every access. Because the refresh period is short, dozens of refreshes interleave with the traffic and the refresh row counter wraps more than once. The short idle limit lets the timed row close be observed directly.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_RCD,
        ST_CAS,
        ST_PRE,
        ST_REF
    } ctl_state_e;

endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
    parameter int ROW_W = 12,
    parameter int COL_W = 9
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic [ROW_W-1:0]       open_row,
    input  logic                   open_valid,
    output logic [ROW_W-1:0]       row,
    output logic [COL_W-1:0]       col,
    output logic                   hit
);

    always_comb begin
        row = addr[ROW_W+COL_W-1:COL_W];
        col = addr[COL_W-1:0];
        hit = open_valid && (row == open_row);
    end

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int ROW_W  = 12,
    parameter int PERIOD = 780
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] row
);

    localparam int TW = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [TW-1:0]    tick;
        logic             pend;
        logic [ROW_W-1:0] row;
    } rt_t;

    rt_t rt_d, rt_q;

    always_comb begin
        rt_d = rt_q;
        if (rt_q.tick == '0) begin
            rt_d.tick = TW'(PERIOD - 1);
        end else begin
            rt_d.tick = rt_q.tick - 1'b1;
        end
        if (ack) begin
            rt_d.pend = 1'b0;
            rt_d.row  = rt_q.row + 1'b1;
        end
        if (rt_q.tick == '0) begin
            rt_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q.tick <= TW'(PERIOD - 1);
            rt_q.pend <= 1'b0;
            rt_q.row  <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign pending = rt_q.pend;
    assign row     = rt_q.row;

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 9,
    parameter int DATA_W     = 8,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 2,
    parameter int T_RP       = 2,
    parameter int T_RAS_REF  = 4,
    parameter int REF_PERIOD = 780,
    parameter int IDLE_CLOSE = 16,
    localparam int ADDR_W    = ROW_W + COL_W,
    localparam int PIN_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ras,
    output logic              mem_cas,
    output logic              mem_we,
    output logic [PIN_W-1:0]  mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int T_MAX1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_MAX2 = (T_RP > T_RAS_REF) ? T_RP : T_RAS_REF;
    localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int CNT_W  = $clog2(T_MAX + 1);
    localparam int IDLE_W = $clog2(IDLE_CLOSE + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [IDLE_W-1:0] idle;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              acc_pend;
        logic [PIN_W-1:0]  pin;
        logic              ras;
        logic              cas;
        logic              we;
        logic [DATA_W-1:0] dout;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             page_hit;
    logic             ref_pend;
    logic             ref_ack;
    logic [ROW_W-1:0] refresh_row;

    dram_addr_split #(
        .ROW_W(ROW_W),
        .COL_W(COL_W)
    ) u_split (
        .addr      (req_addr),
        .open_row  (ctl_q.row),
        .open_valid(ctl_q.st == ST_OPEN),
        .row       (req_row),
        .col       (req_col),
        .hit       (page_hit)
    );

    dram_refresh_timer #(
        .ROW_W (ROW_W),
        .PERIOD(REF_PERIOD)
    ) u_refresh (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack    (ref_ack),
        .pending(ref_pend),
        .row    (refresh_row)
    );

    assign req_ready = ((ctl_q.st == ST_IDLE) || (ctl_q.st == ST_OPEN)) && !ref_pend;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ref_ack    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ctl_d.pin = PIN_W'(refresh_row);
                    ctl_d.ras = 1'b1;
                    ctl_d.cnt = CNT_W'(T_RAS_REF - 1);
                    ctl_d.st  = ST_REF;
                end else if (req_valid) begin
                    ctl_d.row   = req_row;
                    ctl_d.col   = req_col;
                    ctl_d.wr    = req_write;
                    ctl_d.wdata = req_wdata;
                    ctl_d.pin   = PIN_W'(req_row);
                    ctl_d.ras   = 1'b1;
                    ctl_d.cnt   = CNT_W'(T_RCD - 1);
                    ctl_d.st    = ST_RCD;
                end
            end
            ST_OPEN: begin
                if (ref_pend) begin
                    ctl_d.ras      = 1'b0;
                    ctl_d.acc_pend = 1'b0;
                    ctl_d.cnt      = CNT_W'(T_RP - 1);
                    ctl_d.st       = ST_PRE;
                end else if (req_valid) begin
                    ctl_d.row   = req_row;
                    ctl_d.col   = req_col;
                    ctl_d.wr    = req_write;
                    ctl_d.wdata = req_wdata;
                    if (page_hit) begin
                        ctl_d.pin  = PIN_W'(req_col);
                        ctl_d.cas  = 1'b1;
                        ctl_d.we   = req_write;
                        ctl_d.dout = req_wdata;
                        ctl_d.cnt  = CNT_W'(T_CAS - 1);
                        ctl_d.st   = ST_CAS;
                    end else begin
                        ctl_d.ras      = 1'b0;
                        ctl_d.acc_pend = 1'b1;
                        ctl_d.cnt      = CNT_W'(T_RP - 1);
                        ctl_d.st       = ST_PRE;
                    end
                end else if (ctl_q.idle == IDLE_W'(IDLE_CLOSE - 1)) begin
                    ctl_d.ras      = 1'b0;
                    ctl_d.acc_pend = 1'b0;
                    ctl_d.cnt      = CNT_W'(T_RP - 1);
                    ctl_d.st       = ST_PRE;
                end else begin
                    ctl_d.idle = ctl_q.idle + 1'b1;
                end
            end
            ST_RCD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.pin  = PIN_W'(ctl_q.col);
                    ctl_d.cas  = 1'b1;
                    ctl_d.we   = ctl_q.wr;
                    ctl_d.dout = ctl_q.wdata;
                    ctl_d.cnt  = CNT_W'(T_CAS - 1);
                    ctl_d.st   = ST_CAS;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_CAS: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.cas  = 1'b0;
                    ctl_d.we   = 1'b0;
                    ctl_d.done = 1'b1;
                    if (!ctl_q.wr) begin
                        ctl_d.rdata = mem_din;
                    end
                    ctl_d.idle = '0;
                    ctl_d.st   = ST_OPEN;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else if (ctl_q.acc_pend) begin
                    ctl_d.acc_pend = 1'b0;
                    ctl_d.pin      = PIN_W'(ctl_q.row);
                    ctl_d.ras      = 1'b1;
                    ctl_d.cnt      = CNT_W'(T_RCD - 1);
                    ctl_d.st       = ST_RCD;
                end else if (ref_pend) begin
                    ctl_d.pin = PIN_W'(refresh_row);
                    ctl_d.ras = 1'b1;
                    ctl_d.cnt = CNT_W'(T_RAS_REF - 1);
                    ctl_d.st  = ST_REF;
                end else begin
                    ctl_d.st = ST_IDLE;
                end
            end
            ST_REF: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.ras      = 1'b0;
                    ctl_d.acc_pend = 1'b0;
                    ref_ack        = 1'b1;
                    ctl_d.cnt      = CNT_W'(T_RP - 1);
                    ctl_d.st       = ST_PRE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_done  = ctl_q.done;
    assign rsp_rdata = ctl_q.rdata;
    assign mem_ras   = ctl_q.ras;
    assign mem_cas   = ctl_q.cas;
    assign mem_we    = ctl_q.we;
    assign mem_addr  = ctl_q.pin;
    assign mem_dout  = ctl_q.dout;

endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk #(
    parameter int ROW_W  = 12,
    parameter int PIN_W  = 12,
    parameter int DATA_W = 8,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_RP   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              mem_ras,
    input logic              mem_cas,
    input logic              mem_we,
    input logic [PIN_W-1:0]  mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic [ROW_W-1:0]  refresh_row
);

    logic [7:0] ras_hi_q, ras_lo_q, cas_hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_hi_q <= '0;
            ras_lo_q <= 8'hFF;
            cas_hi_q <= '0;
        end else begin
            ras_hi_q <= mem_ras ? ((ras_hi_q == 8'hFF) ? ras_hi_q : ras_hi_q + 1'b1) : 8'd0;
            ras_lo_q <= !mem_ras ? ((ras_lo_q == 8'hFF) ? ras_lo_q : ras_lo_q + 1'b1) : 8'd0;
            cas_hi_q <= mem_cas ? ((cas_hi_q == 8'hFF) ? cas_hi_q : cas_hi_q + 1'b1) : 8'd0;
        end
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cas |-> mem_ras); // R3
    AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cas) |-> (int'(ras_hi_q) >= T_RCD)); // R3
    AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas) |-> (int'(cas_hi_q) == T_CAS)); // R4
    AST_WE_WITH_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_cas); // R4
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cas && $past(mem_cas)) |-> ($stable(mem_we) && $stable(mem_dout) && $stable(mem_addr))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R5
    AST_DONE_AT_CAS_END: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $fell(mem_cas)); // R5
    AST_RP_MET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ras) |-> (int'(ras_lo_q) >= T_RP)); // R11
    AST_REF_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(refresh_row) |-> (refresh_row == ROW_W'($past(refresh_row) + 1'b1))); // R8
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_cas); // R9

endmodule

bind dram_page_ctrl dram_page_ctrl_chk #(
    .ROW_W (ROW_W),
    .PIN_W (PIN_W),
    .DATA_W(DATA_W),
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_RP  (T_RP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .mem_ras    (mem_ras),
    .mem_cas    (mem_cas),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_dout   (mem_dout),
    .refresh_row(refresh_row)
);

// File: tb/dram_page_ctrl_bench.sv
`timescale 1ns/1ps
module dram_page_ctrl_bench;

    localparam int ROW_W      = 4;
    localparam int COL_W      = 3;
    localparam int DATA_W     = 8;
    localparam int T_RCD      = 2;
    localparam int T_CAS      = 2;
    localparam int T_RP       = 2;
    localparam int T_RAS_REF  = 3;
    localparam int REF_PERIOD = 50;
    localparam int IDLE_CLOSE = 6;
    localparam int PIN_W      = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int ROWS       = 1 << ROW_W;
    localparam int COLS       = 1 << COL_W;
    localparam int N          = ROWS * COLS;
    localparam int SLACK      = 16;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    req_valid = 1'b0;
    logic                    req_write = 1'b0;
    logic [ROW_W+COL_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0]       req_wdata = '0;
    logic                    req_ready, rsp_done, mem_ras, mem_cas, mem_we;
    logic [DATA_W-1:0]       rsp_rdata, mem_dout, mem_din;
    logic [PIN_W-1:0]        mem_addr;

    always #10 clk = ~clk;

    dram_page_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS_REF(T_RAS_REF),
        .REF_PERIOD(REF_PERIOD), .IDLE_CLOSE(IDLE_CLOSE)
    ) u_dram_page_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_ras(mem_ras), .mem_cas(mem_cas), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural memory array
    logic [DATA_W-1:0] mdl [ROWS][COLS];
    int open_row = 0;
    assign mem_din = mem_cas ? mdl[open_row][mem_addr[COL_W-1:0]] : '0;

    // request tracking shared with the monitor
    bit outstanding = 0;
    bit act_seen    = 0;
    bit fell_flag   = 0;
    int cur_row = 0, cur_col = 0, cur_wdata = 0;
    bit cur_write = 0;

    // pin monitor state
    bit prev_ras = 0, prev_cas = 0, prev_we = 0, in_ref = 0;
    int prev_addr = 0, prev_dout = 0;
    int ras_run = 0, low_run = 1000, cas_run = 0;
    int cyc = 0, last_ref = 0, ref_count = 0, exp_ref_row = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (mem_ras && !prev_ras) begin
                chk(low_run >= T_RP, "R11 precharge cycles", low_run, T_RP);
                open_row = int'(mem_addr[ROW_W-1:0]);
                if (outstanding) begin
                    act_seen = 1;
                    chk(int'(mem_addr) == cur_row, "R2 row on pins", int'(mem_addr), cur_row);
                end else begin
                    in_ref = 1;
                    chk(int'(mem_addr) == exp_ref_row, "R8 refresh row", int'(mem_addr), exp_ref_row);
                    chk((cyc - last_ref) <= REF_PERIOD + SLACK, "R9 refresh gap max", cyc - last_ref, REF_PERIOD + SLACK);
                    if (ref_count > 0)
                        chk((cyc - last_ref) >= REF_PERIOD - SLACK, "R8 refresh gap min", cyc - last_ref, REF_PERIOD - SLACK);
                    exp_ref_row = (exp_ref_row + 1) % ROWS;
                    last_ref = cyc;
                    ref_count++;
                end
            end
            if (!mem_ras && prev_ras) begin
                fell_flag = 1;
                if (in_ref)
                    chk(ras_run == T_RAS_REF, "R8 refresh length", ras_run, T_RAS_REF);
                in_ref = 0;
            end
            if (in_ref && mem_cas)
                chk(0, "R8 column pulse in refresh", 1, 0);
            if (mem_cas && !prev_cas) begin
                chk(ras_run >= T_RCD, "R3 row-to-column delay", ras_run, T_RCD);
                chk(int'(mem_addr) == cur_col, "R2 column on pins", int'(mem_addr), cur_col);
                chk(mem_we == cur_write, "R4 write enable", int'(mem_we), int'(cur_write));
                if (cur_write)
                    chk(int'(mem_dout) == cur_wdata, "R4 write data", int'(mem_dout), cur_wdata);
            end
            if (mem_cas && prev_cas) begin
                chk(mem_we == prev_we && int'(mem_dout) == prev_dout && int'(mem_addr) == prev_addr,
                    "R4 hold during pulse", int'(mem_addr), prev_addr);
            end
            if (mem_cas)
                chk(mem_ras, "R3 column under row", int'(mem_ras), 1);
            if (mem_we && !mem_cas)
                chk(0, "R4 write enable outside pulse", 1, 0);
            if (!mem_cas && prev_cas) begin
                chk(cas_run == T_CAS, "R4 pulse width", cas_run, T_CAS);
                chk(rsp_done, "R5 done at pulse end", int'(rsp_done), 1);
            end
            if (mem_cas && mem_we)
                mdl[open_row][mem_addr[COL_W-1:0]] = mem_dout;
            ras_run  = mem_ras ? ras_run + 1 : 0;
            low_run  = mem_ras ? 0 : low_run + 1;
            cas_run  = mem_cas ? cas_run + 1 : 0;
            prev_ras = mem_ras;
            prev_cas = mem_cas;
            prev_we  = mem_we;
            prev_addr = int'(mem_addr);
            prev_dout = int'(mem_dout);
        end
    end

    logic [DATA_W-1:0] shadow [N];
    int  last_row   = 0;
    bit  last_row_v = 0;

    task automatic access(input bit wr, input int a, input int wd, output int rd);
        bit exp_act;
        @(negedge clk);
        req_write = wr;
        req_addr  = (ROW_W+COL_W)'(a);
        req_wdata = DATA_W'(wd);
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        cur_row   = a >> COL_W;
        cur_col   = a % COLS;
        cur_write = wr;
        cur_wdata = wd & 255;
        act_seen  = 0;
        exp_act   = !(mem_ras && last_row_v && (last_row == cur_row));
        outstanding = 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        outstanding = 0;
        rd = int'(rsp_rdata);
        if (exp_act)
            chk(act_seen == 1, "R7 row switch activates", int'(act_seen), 1);
        else
            chk(act_seen == 0, "R6 page hit without activation", int'(act_seen), 0);
        last_row   = cur_row;
        last_row_v = 1;
        if (wr) shadow[a] = DATA_W'(wd);
        @(negedge clk);
        chk(!rsp_done, "R5 single done pulse", int'(rsp_done), 0);
    endtask

    task automatic rd_check(input int a);
        int v;
        access(0, a, 0, v);
        chk(v == int'(shadow[a]), "R12 read data", v, int'(shadow[a]));
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int dummy;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                mdl[r][c] = '0;
        for (int i = 0; i < N; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!mem_ras && !mem_cas && !mem_we && !rsp_done, "R1 strobes low", int'(mem_ras) + int'(mem_cas), 0);
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

        // row-major writes: long page-hit runs
        for (int i = 0; i < N; i++) access(1, i, (i * 29 + 3), dummy);
        for (int i = 0; i < N; i++) rd_check(i);
        // strided reads: mostly row switches
        for (int i = 0; i < N; i++) rd_check((i * 45 + 7) % N);
        // column-major writes then reverse row-major reads
        for (int i = 0; i < N; i++) access(1, (i % ROWS) * COLS + (i / ROWS), (i * 71 + 11), dummy);
        for (int i = N - 1; i >= 0; i--) rd_check(i);
        // write then read the same address pairwise
        for (int i = 0; i < N; i++) begin
            int a;
            a = (i * 77 + 5) % N;
            access(1, a, (a * 13 + i), dummy);
            rd_check(a);
        end
        // R10 timed close of an idle row
        for (int k = 0; k < 3; k++) begin
            access(1, k * 9, k + 100, dummy);
            fell_flag = 0;
            repeat (IDLE_CLOSE - 1) @(negedge clk);
            chk(fell_flag || !mem_ras, "R10 idle close", int'(mem_ras), 0);
            repeat (4) @(negedge clk);
            rd_check(k * 9);
        end
        // R8 refresh activity over the run
        chk(ref_count >= cyc / (REF_PERIOD + SLACK), "R8 refresh count", ref_count, cyc / (REF_PERIOD + SLACK));
        chk(ref_count > ROWS, "R8 refresh row wrap", ref_count, ROWS + 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule